// File: doc/BRIEF.md
# Ordered Word Buffer with Stream-Close Marker

This block sits between a producing stage and a consuming stage of a hardware pipeline, on one clock. The producer offers a word, together with a flag that says "this is my last word", whenever the buffer reports that it has room. The consumer takes words in arrival order whenever the buffer reports that one is waiting. The close flag is stored next to its word, so the consumer sees the stream end at the point in the data where the producer closed it, and not before.

The head word is shown on the read side before it is taken (show-ahead). A read enable removes that word at the next clock edge. Both sides may transfer in the same cycle. The storage is a ring of `DEPTH` entries, each `WIDTH` data bits plus one flag bit. The ring wraps correctly at any depth, including depths that are not a power of two. The reset is synchronous and active high.

Top module: `sbuf_stream`

## Requirements
- R1: Words leave in the order they were accepted. While `rd_ready` is high, `rd_data` shows the oldest stored word, and it stays unchanged until that word is read.
- R2: A word and its flag are stored at a rising edge exactly when `wr_en` and `wr_ready` are both high at that edge.
- R3: `wr_ready` is low exactly when `DEPTH` entries are stored. This holds even when a read is requested in the same cycle, so a write offered while full is not taken.
- R4: `rd_ready` is high exactly when at least one entry is stored. An entry is removed at a rising edge exactly when `rd_en` and `rd_ready` are both high.
- R5: The end-of-stream flag sampled from `wr_eos` with a write is kept with that word. `rd_eos` equals the flag of the head entry.
- R6: A `wr_en` while `wr_ready` is low changes nothing: the entries already stored drain with unchanged data and flags.
- R7: A `rd_en` while `rd_ready` is low changes nothing: the buffer stays empty and a later write is read back normally.
- R8: While the buffer is empty, `rd_data` is all zeros and `rd_eos` is 0.
- R9: With `rst` high at a rising edge, the buffer empties and all stored flags are cleared. After that edge `wr_ready` is 1, `rd_ready` is 0 and `rd_eos` is 0.
- R10: A write and a read accepted in the same cycle leave the number of stored entries unchanged.
- R11: The storage positions wrap after `DEPTH` entries for any `DEPTH` of at least 1, so order is kept over any number of laps of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_ready | output | 1 | Buffer has room for a word |
| wr_en | input | 1 | Producer offers a word this cycle |
| wr_eos | input | 1 | The offered word closes the stream |
| wr_data | input | WIDTH | Offered word |
| rd_ready | output | 1 | A word is waiting at the head |
| rd_en | input | 1 | Consumer takes the head word this cycle |
| rd_eos | output | 1 | Head word closes the stream |
| rd_data | output | WIDTH | Head word |

## Verification
The bench builds the block with `WIDTH` 8 and `DEPTH` 3. A depth that is not a power of two makes the position counters wrap at a value below their natural roll-over. Long traffic therefore exercises the wrap many times, at positions where a power-of-two shortcut would fail. The small depth also lets full and empty, and writes and reads at the full and empty boundaries, occur often within a short run.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // Position after p in a ring of the given depth.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 >= depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned level_next(int unsigned lvl, bit push, bit pop);
    int unsigned n;
    n = lvl;
    if (push) n = n + 1;
    if (pop)  n = n - 1;
    return n;
  endfunction

  // Width of a ring position for a given depth.
  function automatic int unsigned ptr_bits(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/sbuf_ctrl.sv
module sbuf_ctrl
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic          full,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] rptr,
  output logic [LW-1:0] level
);

  logic [PW-1:0] wptr_q;
  logic [PW-1:0] rptr_q;
  logic [LW-1:0] level_q;
  logic          empty;

  assign full  = (level_q == LW'(DEPTH));
  assign empty = (level_q == '0);
  assign push  = wr_en & ~full;
  assign pop   = rd_en & ~empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push) wptr_q <= PW'(ring_next(32'(wptr_q), DEPTH));
      if (pop)  rptr_q <= PW'(ring_next(32'(rptr_q), DEPTH));
      level_q <= LW'(level_next(32'(level_q), push, pop));
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign level = level_q;

endmodule

// File: rtl/sbuf_store.sv
module sbuf_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [PW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             weos,
  input  logic [PW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata,
  output logic             reos
);

  logic [WIDTH-1:0] data_q [DEPTH];
  logic             flag_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        data_q[i] <= '0;
        flag_q[i] <= 1'b0;
      end else if (we && (waddr == PW'(i))) begin
        data_q[i] <= wdata;
        flag_q[i] <= weos;
      end
    end
  end

  assign rdata = data_q[raddr];
  assign reos  = flag_q[raddr];

endmodule

// File: rtl/sbuf_head.sv
module sbuf_head #(
  parameter int WIDTH = 8,
  parameter int LW    = 3
) (
  input  logic [LW-1:0]    level,
  input  logic [WIDTH-1:0] mem_data,
  input  logic             mem_eos,
  output logic             valid,
  output logic [WIDTH-1:0] data,
  output logic             eos
);

  assign valid = (level != '0);
  assign data  = valid ? mem_data : '0;
  assign eos   = valid & mem_eos;

endmodule

// File: rtl/sbuf_stream.sv
module sbuf_stream
  import sbuf_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic             wr_ready,
  input  logic             wr_en,
  input  logic             wr_eos,
  input  logic [WIDTH-1:0] wr_data,
  output logic             rd_ready,
  input  logic             rd_en,
  output logic             rd_eos,
  output logic [WIDTH-1:0] rd_data
);

  localparam int PW = ptr_bits(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic          full;
  logic          push_evt;
  logic          pop_evt;
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic [LW-1:0] level;

  logic [WIDTH-1:0] head_data;
  logic             head_eos;

  sbuf_ctrl #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) i_ctrl (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .full  (full),
    .push  (push_evt),
    .pop   (pop_evt),
    .wptr  (wptr),
    .rptr  (rptr),
    .level (level)
  );

  sbuf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PW(PW)) i_store (
    .clk   (clk),
    .rst   (rst),
    .we    (push_evt),
    .waddr (wptr),
    .wdata (wr_data),
    .weos  (wr_eos),
    .raddr (rptr),
    .rdata (head_data),
    .reos  (head_eos)
  );

  sbuf_head #(.WIDTH(WIDTH), .LW(LW)) i_head (
    .level    (level),
    .mem_data (head_data),
    .mem_eos  (head_eos),
    .valid    (rd_ready),
    .data     (rd_data),
    .eos      (rd_eos)
  );

  assign wr_ready = ~full;

endmodule

// File: rtl/sbuf_stream_chk.sv
module sbuf_stream_chk #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_ready,
  input logic             wr_en,
  input logic             rd_ready,
  input logic             rd_en,
  input logic             rd_eos,
  input logic [WIDTH-1:0] rd_data,
  input logic             push,
  input logic             pop,
  input logic [LW-1:0]    level
);

  AST_RESET_EMPTIES: assert property (@(posedge clk)
    rst |=> (level == '0) && !rd_ready && wr_ready && !rd_eos); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH)); // R3

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (level == LW'(DEPTH)) |-> !wr_ready); // R3

  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> level == $past(level) + 1'b1); // R2

  AST_BOTH_KEEP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> $stable(level)); // R10

  AST_FULL_IGNORES_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && !rd_en) |=> !wr_ready && $stable(rd_data) && $stable(rd_eos)); // R6

  AST_EMPTY_IGNORES_READ: assert property (@(posedge clk) disable iff (rst)
    (!rd_ready && !wr_en) |=> !rd_ready); // R7

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_ready |-> (rd_data == '0) && !rd_eos); // R8

  AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_ready && !rd_en) |=> rd_ready && $stable(rd_data) && $stable(rd_eos)); // R1

  AST_READY_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (rst)
    rd_ready == (level != '0)); // R4

endmodule

bind sbuf_stream sbuf_stream_chk #(
  .WIDTH (WIDTH),
  .DEPTH (DEPTH),
  .LW    (LW)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_ready (wr_ready),
  .wr_en    (wr_en),
  .rd_ready (rd_ready),
  .rd_en    (rd_en),
  .rd_eos   (rd_eos),
  .rd_data  (rd_data),
  .push     (push_evt),
  .pop      (pop_evt),
  .level    (level)
);

// File: tb/test_sbuf_stream.sv
module test_sbuf_stream;

  localparam int W = 8;
  localparam int D = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic         wr_eos = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic         wr_ready;
  logic         rd_ready;
  logic         rd_eos;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference contents: bit W is the close flag, low bits the word.
  logic [W:0] model [$];

  always #5 clk = ~clk;

  sbuf_stream #(.WIDTH(W), .DEPTH(D)) i_sbuf_stream (
    .clk      (clk),
    .rst      (rst),
    .wr_ready (wr_ready),
    .wr_en    (wr_en),
    .wr_eos   (wr_eos),
    .wr_data  (wr_data),
    .rd_ready (rd_ready),
    .rd_en    (rd_en),
    .rd_eos   (rd_eos),
    .rd_data  (rd_data)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Compare every output against the reference, tagging the context.
  task automatic compare(input string ctx);
    logic         e_wr;
    logic         e_rd;
    logic [W-1:0] e_data;
    logic         e_eos;
    e_wr   = (model.size() < D);
    e_rd   = (model.size() > 0);
    e_data = e_rd ? model[0][W-1:0] : '0;
    e_eos  = e_rd ? model[0][W] : 1'b0;
    check(wr_ready == e_wr, {"R3 wr_ready ", ctx}, int'(wr_ready), int'(e_wr));
    check(rd_ready == e_rd, {"R4 rd_ready ", ctx}, int'(rd_ready), int'(e_rd));
    check(rd_data == e_data, {"R1/R8 rd_data ", ctx}, int'(rd_data), int'(e_data));
    check(rd_eos == e_eos, {"R5/R8 rd_eos ", ctx}, int'(rd_eos), int'(e_eos));
  endtask

  // One cycle: drive at the falling edge, check, then update the model at the rising edge.
  task automatic step(input logic we, input logic weos, input logic [W-1:0] wd,
                      input logic re, input string ctx);
    bit acc_w;
    bit acc_r;
    wr_en   = we;
    wr_eos  = weos;
    wr_data = wd;
    rd_en   = re;
    compare(ctx);
    acc_w = we && (model.size() < D);
    acc_r = re && (model.size() > 0);
    @(posedge clk);
    if (acc_r) void'(model.pop_front());
    if (acc_w) model.push_back({weos, wd});
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    repeat (2) @(posedge clk);
    model.delete();
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R9: state after reset
    check(wr_ready == 1'b1, "R9 wr_ready after reset", int'(wr_ready), 1);
    check(rd_ready == 1'b0, "R9 rd_ready after reset", int'(rd_ready), 0);
    check(rd_eos == 1'b0, "R9 rd_eos after reset", int'(rd_eos), 0);
    check(rd_data == '0, "R8 rd_data empty after reset", int'(rd_data), 0);

    // R7: reads on an empty buffer are ignored
    step(1'b0, 1'b0, 8'h00, 1'b1, "R7 read on empty");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R7 read on empty");
    step(1'b1, 1'b0, 8'h5A, 1'b0, "R2 write after empty reads");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R1 head shown");
    check(rd_data == 8'h5A, "R7 word after ignored reads", int'(rd_data), 'h5A);
    step(1'b0, 1'b0, 8'h00, 1'b1, "R4 read one");

    // Fill to full, last word closes the stream
    step(1'b1, 1'b0, 8'h11, 1'b0, "R2 fill");
    step(1'b1, 1'b0, 8'h22, 1'b0, "R2 fill");
    step(1'b1, 1'b1, 8'h33, 1'b0, "R5 fill with close");
    check(wr_ready == 1'b0, "R3 full at DEPTH", int'(wr_ready), 0);
    // R6: writes while full are ignored
    step(1'b1, 1'b0, 8'hEE, 1'b0, "R6 write on full");
    step(1'b1, 1'b1, 8'hDD, 1'b0, "R6 write on full");
    // R3: write plus read while full - the write is not taken
    step(1'b1, 1'b0, 8'hCC, 1'b1, "R3 write and read on full");
    check(rd_data == 8'h22, "R6 head after rejected writes", int'(rd_data), 'h22);
    step(1'b0, 1'b0, 8'h00, 1'b1, "R1 drain");
    check(rd_eos == 1'b1, "R5 close marker at head", int'(rd_eos), 1);
    check(rd_data == 8'h33, "R5 close word", int'(rd_data), 'h33);
    step(1'b0, 1'b0, 8'h00, 1'b1, "R1 drain last");
    check(rd_ready == 1'b0, "R6 nothing extra stored", int'(rd_ready), 0);

    // R10: write and read together mid-level
    step(1'b1, 1'b0, 8'h41, 1'b0, "R10 setup");
    step(1'b1, 1'b0, 8'h42, 1'b1, "R10 write and read");
    step(1'b1, 1'b1, 8'h43, 1'b1, "R10 write and read");
    check(wr_ready == 1'b1 && rd_ready == 1'b1, "R10 level kept at one",
          int'({wr_ready, rd_ready}), 3);
    step(1'b0, 1'b0, 8'h00, 1'b1, "R10 drain");

    // R11: many laps of the ring with mixed traffic
    for (int i = 0; i < 600; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[0] | r[1], (r[5:4] == 2'b11), W'(r >> 8), r[2] | (i > 300 && r[3]),
           "R11 mixed traffic");
    end

    // R9: reset with entries holding close flags
    while (model.size() < D) step(1'b1, 1'b1, 8'hA5, 1'b0, "R9 fill before reset");
    do_reset();
    check(rd_ready == 1'b0, "R9 emptied by reset", int'(rd_ready), 0);
    check(rd_eos == 1'b0, "R9 flags cleared", int'(rd_eos), 0);
    step(1'b1, 1'b0, 8'h77, 1'b0, "R9 write after reset");
    check(rd_eos == 1'b0, "R9 stale flag not seen", int'(rd_eos), 0);
    step(1'b0, 1'b0, 8'h00, 1'b1, "R9 final read");
    compare("R8 final empty");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule